// File: doc/BRIEF.md
# Two-Instruction Word Fetch Front End

This block is the instruction fetch and decode front end of a 40-bit accumulator machine whose memory words each hold two 20-bit instructions. The upper 20 bits of a word form the first instruction and the lower 20 bits form the second. Every instruction is an 8-bit opcode in its upper bits and a 12-bit address field in its lower bits. The unit keeps a program counter, places addresses on memory through a memory address register, and captures returned words in a memory data register. It then splits each word: the first instruction goes into the instruction register and the second is kept in a buffer register, so the second instruction reaches the execute stage with no further memory read.

Instructions are handed to the execute stage one at a time over a valid/ready handshake, and fetch stalls until the current one is taken. The execute stage may also redirect the flow to any word and either half of it. While an instruction is waiting, it can ask for the operand named by that instruction's address field. Code and data share one 4096-word space, and the address field is used exactly as written. The control state machine has eight states. ST_FETCH loads the address register from the program counter and starts a read. ST_WAIT covers memory latency. ST_CAPTURE loads the data register. ST_SPLIT fills the instruction and buffer registers. ST_ISSUE offers the instruction. ST_DREAD, ST_DWAIT and ST_DCAP perform the operand read.

The state machine has these transitions. FETCH→WAIT→CAPTURE→SPLIT→ISSUE. On a handshake of a first-half instruction with the buffer full, ISSUE→ISSUE, refilled from the buffer. On a handshake of a second-half instruction, ISSUE→FETCH and the program counter increments. On an operand request while stalled, ISSUE→DREAD→DWAIT→DCAP→ISSUE. From any state, a redirect goes to FETCH.

Top module: `dual_slot_fetch`

## Requirements
- R1: A synchronous reset clears the program counter to word 0 and invalidates the buffer. In the cycle after reset, iss_valid, mem_rd and data_valid are 0. The first read after reset is of word 0, and its first instruction is issued first.
- R2: An instruction read drives mem_rd high for exactly one cycle, with mem_addr equal to the program counter. The word returned by the memory one clock later is the one that is decoded.
- R3: For a word fetched in sequence, the first issued instruction has iss_half = 0, iss_opcode = word bits 39..32 and iss_addr = word bits 31..20.
- R4: In the cycle after a handshake on an iss_half = 0 instruction, with no redirect, iss_valid is 1 and iss_half is 1. The payload is the second instruction of the same word (iss_opcode = bits 19..12, iss_addr = bits 11..0), and mem_rd is 0.
- R5: The program counter advances by one, wrapping at 4096, only after a handshake on an iss_half = 1 instruction. The next instruction read is then at the incremented address.
- R6: While iss_valid is 1 and iss_ready is 0, with no redirect and no operand request, iss_valid stays 1 and iss_opcode, iss_addr and iss_half hold their values.
- R7: A redirect (redir_valid = 1) in any state discards the buffered instruction and any read in progress. iss_valid is 0 in the next cycle, and the next read is of word redir_word. With redir_half = 1, only that word's second instruction is issued, followed by a read of the next word. With redir_half = 0, the first and then the second instruction are issued.
- R8: A redirect takes priority over a handshake or operand request in the same cycle.
- R9: An operand request (data_req = 1 while iss_valid = 1 and iss_ready = 0) reads memory at the pending instruction's 12-bit address field unmodified. data_valid then pulses with data_word equal to that memory word, and the same instruction is offered again afterwards.
- R10: data_req has no effect when iss_valid is 0 or iss_ready is 1. No operand read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 12 | Memory address register contents |
| mem_rd | output | 1 | Memory read strobe, one cycle |
| mem_rdata | input | 40 | Word returned by memory one clock after the read strobe |
| iss_valid | output | 1 | An instruction is offered to execute |
| iss_ready | input | 1 | Execute accepts the offered instruction |
| iss_opcode | output | 8 | Opcode of the offered instruction |
| iss_addr | output | 12 | Address field of the offered instruction |
| iss_half | output | 1 | 0: first instruction of its word, 1: second |
| data_req | input | 1 | Request for the operand of the pending instruction |
| data_valid | output | 1 | Operand word is present on data_word |
| data_word | output | 40 | Memory data register contents |
| redir_valid | input | 1 | Branch redirect |
| redir_word | input | 12 | Redirect target word |
| redir_half | input | 1 | Redirect target half, 1 selects the second instruction |

## Verification
The bench runs a random mix of ready-held-high streams, long stalls, operand requests raised during stalls, and redirects to either half landing in every state. Each is scored against a behavioural model that tracks the next expected word and half. Back-to-back acceptance separates buffer reuse from a spurious second memory read. Stalls expose payload changes or a dropped valid. Second-half redirects reveal a wrong first slot or a missed increment. Operand requests at random address fields show whether the address register takes the field unmodified and whether the held instruction survives the read. A mid-run reset repeats the reset-state and first-read checks.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
    typedef enum logic [2:0] {
        ST_FETCH,
        ST_WAIT,
        ST_CAPTURE,
        ST_SPLIT,
        ST_ISSUE,
        ST_DREAD,
        ST_DWAIT,
        ST_DCAP
    } fstate_t;

    typedef enum logic {
        MAR_FROM_PC,
        MAR_FROM_IR
    } mar_src_t;
endpackage

// File: rtl/word_split.sv
module word_split #(
    parameter int SLOT_W = 20,
    parameter int SLOTS  = 2
) (
    input  logic [SLOT_W*SLOTS-1:0]     word_in,
    output logic [SLOTS-1:0][SLOT_W-1:0] slot_out
);
    // slot index SLOTS-1 is the upper (issued first) instruction
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        assign slot_out[s] = word_in[s*SLOT_W +: SLOT_W];
    end
endmodule

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
    import fetch_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     iss_ready,
    input  logic     redir_valid,
    input  logic     data_req,
    input  logic     cur_half,
    input  logic     ibr_valid,
    output logic     issue_now,
    output logic     pc_ld,
    output logic     pc_inc,
    output logic     mar_ld,
    output mar_src_t mar_src,
    output logic     rd_set,
    output logic     mdr_ld,
    output logic     ir_ld_split,
    output logic     ir_ld_ibr,
    output logic     ibr_inv,
    output logic     dvalid_set
);
    fstate_t state, nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= nxt;
    end

    always_comb begin
        nxt         = state;
        pc_ld       = 1'b0;
        pc_inc      = 1'b0;
        mar_ld      = 1'b0;
        mar_src     = MAR_FROM_PC;
        rd_set      = 1'b0;
        mdr_ld      = 1'b0;
        ir_ld_split = 1'b0;
        ir_ld_ibr   = 1'b0;
        ibr_inv     = 1'b0;
        dvalid_set  = 1'b0;
        issue_now   = (state == ST_ISSUE);
        if (redir_valid) begin
            pc_ld   = 1'b1;
            ibr_inv = 1'b1;
            nxt     = ST_FETCH;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    mar_ld = 1'b1;
                    rd_set = 1'b1;
                    nxt    = ST_WAIT;
                end
                ST_WAIT:    nxt = ST_CAPTURE;
                ST_CAPTURE: begin
                    mdr_ld = 1'b1;
                    nxt    = ST_SPLIT;
                end
                ST_SPLIT: begin
                    ir_ld_split = 1'b1;
                    nxt         = ST_ISSUE;
                end
                ST_ISSUE: begin
                    if (iss_ready) begin
                        if (!cur_half && ibr_valid) begin
                            ir_ld_ibr = 1'b1;
                            nxt       = ST_ISSUE;
                        end else begin
                            pc_inc = 1'b1;
                            nxt    = ST_FETCH;
                        end
                    end else if (data_req) begin
                        nxt = ST_DREAD;
                    end
                end
                ST_DREAD: begin
                    mar_ld  = 1'b1;
                    mar_src = MAR_FROM_IR;
                    rd_set  = 1'b1;
                    nxt     = ST_DWAIT;
                end
                ST_DWAIT:   nxt = ST_DCAP;
                ST_DCAP: begin
                    mdr_ld     = 1'b1;
                    dvalid_set = 1'b1;
                    nxt        = ST_ISSUE;
                end
                default:    nxt = ST_FETCH;
            endcase
        end
    end
endmodule

// File: rtl/fetch_regs.sv
module fetch_regs
    import fetch_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OPC_W  = 8,
    localparam int SLOT_W = OPC_W + ADDR_W,
    localparam int WORD_W = 2 * SLOT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pc_ld,
    input  logic              pc_inc,
    input  logic              mar_ld,
    input  mar_src_t          mar_src,
    input  logic              rd_set,
    input  logic              mdr_ld,
    input  logic              ir_ld_split,
    input  logic              ir_ld_ibr,
    input  logic              ibr_inv,
    input  logic              dvalid_set,
    input  logic [ADDR_W-1:0] redir_word,
    input  logic              redir_half,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mar_q,
    output logic              rd_q,
    output logic [WORD_W-1:0] mdr_q,
    output logic [SLOT_W-1:0] ir_q,
    output logic              ir_half_q,
    output logic              ibr_valid_q,
    output logic              dvalid_q
);
    localparam logic [ADDR_W-1:0] PC_STEP = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0]          pc_q;
    logic                       start_half_q;
    logic [SLOT_W-1:0]          ibr_q;
    logic [1:0][SLOT_W-1:0]     slots;

    word_split #(.SLOT_W(SLOT_W), .SLOTS(2)) split_i (
        .word_in  (mdr_q),
        .slot_out (slots)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q         <= '0;
            start_half_q <= 1'b0;
        end else if (pc_ld) begin
            pc_q         <= redir_word;
            start_half_q <= redir_half;
        end else if (pc_inc) begin
            pc_q         <= pc_q + PC_STEP;
            start_half_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mar_q    <= '0;
            rd_q     <= 1'b0;
            mdr_q    <= '0;
            dvalid_q <= 1'b0;
        end else begin
            rd_q     <= rd_set;
            dvalid_q <= dvalid_set;
            if (mar_ld) mar_q <= (mar_src == MAR_FROM_IR) ? ir_q[ADDR_W-1:0] : pc_q;
            if (mdr_ld) mdr_q <= mem_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ir_q        <= '0;
            ir_half_q   <= 1'b0;
            ibr_q       <= '0;
            ibr_valid_q <= 1'b0;
        end else if (ibr_inv) begin
            ibr_valid_q <= 1'b0;
        end else if (ir_ld_split) begin
            ir_q        <= start_half_q ? slots[0] : slots[1];
            ir_half_q   <= start_half_q;
            ibr_q       <= slots[0];
            ibr_valid_q <= !start_half_q;
        end else if (ir_ld_ibr) begin
            ir_q        <= ibr_q;
            ir_half_q   <= 1'b1;
            ibr_valid_q <= 1'b0;
        end
    end
endmodule

// File: rtl/dual_slot_fetch.sv
module dual_slot_fetch
    import fetch_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int OPC_W  = 8,
    localparam int SLOT_W = OPC_W + ADDR_W,
    localparam int WORD_W = 2 * SLOT_W
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [OPC_W-1:0]  iss_opcode,
    output logic [ADDR_W-1:0] iss_addr,
    output logic              iss_half,
    input  logic              data_req,
    output logic              data_valid,
    output logic [WORD_W-1:0] data_word,
    input  logic              redir_valid,
    input  logic [ADDR_W-1:0] redir_word,
    input  logic              redir_half
);
    logic     pc_ld, pc_inc, mar_ld, rd_set, mdr_ld;
    logic     ir_ld_split, ir_ld_ibr, ibr_inv, dvalid_set;
    mar_src_t mar_src;
    logic     ir_half_q, ibr_valid_q;
    logic [SLOT_W-1:0] ir_q;

    fetch_ctrl ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .iss_ready   (iss_ready),
        .redir_valid (redir_valid),
        .data_req    (data_req),
        .cur_half    (ir_half_q),
        .ibr_valid   (ibr_valid_q),
        .issue_now   (iss_valid),
        .pc_ld       (pc_ld),
        .pc_inc      (pc_inc),
        .mar_ld      (mar_ld),
        .mar_src     (mar_src),
        .rd_set      (rd_set),
        .mdr_ld      (mdr_ld),
        .ir_ld_split (ir_ld_split),
        .ir_ld_ibr   (ir_ld_ibr),
        .ibr_inv     (ibr_inv),
        .dvalid_set  (dvalid_set)
    );

    fetch_regs #(.ADDR_W(ADDR_W), .OPC_W(OPC_W)) regs_i (
        .clk         (clk),
        .rst         (rst),
        .pc_ld       (pc_ld),
        .pc_inc      (pc_inc),
        .mar_ld      (mar_ld),
        .mar_src     (mar_src),
        .rd_set      (rd_set),
        .mdr_ld      (mdr_ld),
        .ir_ld_split (ir_ld_split),
        .ir_ld_ibr   (ir_ld_ibr),
        .ibr_inv     (ibr_inv),
        .dvalid_set  (dvalid_set),
        .redir_word  (redir_word),
        .redir_half  (redir_half),
        .mem_rdata   (mem_rdata),
        .mar_q       (mem_addr),
        .rd_q        (mem_rd),
        .mdr_q       (data_word),
        .ir_q        (ir_q),
        .ir_half_q   (ir_half_q),
        .ibr_valid_q (ibr_valid_q),
        .dvalid_q    (data_valid)
    );

    assign iss_opcode = ir_q[SLOT_W-1 -: OPC_W];
    assign iss_addr   = ir_q[ADDR_W-1:0];
    assign iss_half   = ir_half_q;
endmodule

// File: rtl/dual_slot_fetch_chk.sv
module dual_slot_fetch_chk #(
    parameter int ADDR_W = 12,
    parameter int OPC_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_rd,
    input logic              iss_valid,
    input logic              iss_ready,
    input logic [OPC_W-1:0]  iss_opcode,
    input logic [ADDR_W-1:0] iss_addr,
    input logic              iss_half,
    input logic              data_req,
    input logic              data_valid,
    input logic              redir_valid
);
    logic rst_d = 1'b0;
    always @(posedge clk) rst_d <= rst;

    always @(posedge clk) begin
        if (rst_d) begin
            assert_reset_quiet_R1: assert (!iss_valid && !mem_rd && !data_valid);
        end
    end

    assert_read_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    assert_right_from_buffer_R4: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_ready && !iss_half && !redir_valid) |=> (iss_valid && iss_half && !mem_rd));

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_ready && !redir_valid && !data_req)
        |=> (iss_valid && $stable(iss_opcode) && $stable(iss_addr) && $stable(iss_half)));

    assert_redirect_drops_R7: assert property (@(posedge clk) disable iff (rst)
        redir_valid |=> !iss_valid);

    assert_operand_with_pending_R9: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> iss_valid);
endmodule

bind dual_slot_fetch dual_slot_fetch_chk #(.ADDR_W(ADDR_W), .OPC_W(OPC_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .mem_rd      (mem_rd),
    .iss_valid   (iss_valid),
    .iss_ready   (iss_ready),
    .iss_opcode  (iss_opcode),
    .iss_addr    (iss_addr),
    .iss_half    (iss_half),
    .data_req    (data_req),
    .data_valid  (data_valid),
    .redir_valid (redir_valid)
);

// File: tb/dual_slot_fetch_tb_top.sv
module dual_slot_fetch_tb_top;
    localparam int AW = 12;
    localparam int OW = 8;
    localparam int WW = 40;
    localparam int DEPTH = 4096;
    localparam int RUN_CYCLES = 20000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] mem_addr;
    logic          mem_rd;
    logic [WW-1:0] mem_rdata = '0;
    logic          iss_valid;
    logic          iss_ready = 1'b0;
    logic [OW-1:0] iss_opcode;
    logic [AW-1:0] iss_addr;
    logic          iss_half;
    logic          data_req = 1'b0;
    logic          data_valid;
    logic [WW-1:0] data_word;
    logic          redir_valid = 1'b0;
    logic [AW-1:0] redir_word = '0;
    logic          redir_half = 1'b0;

    logic [WW-1:0] mem [DEPTH];

    int checks = 0;
    int errors = 0;
    int accepts = 0;
    int half2_issues = 0;
    int data_results = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dual_slot_fetch dut_i (
        .clk(clk), .rst(rst),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .iss_valid(iss_valid), .iss_ready(iss_ready),
        .iss_opcode(iss_opcode), .iss_addr(iss_addr), .iss_half(iss_half),
        .data_req(data_req), .data_valid(data_valid), .data_word(data_word),
        .redir_valid(redir_valid), .redir_word(redir_word), .redir_half(redir_half)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint actual, input longint expected);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, actual, expected);
        end
    endtask

    // reference state
    int  pc_m;
    bit  half_m;
    bit  d_pend, d_read_seen;
    int  daddr_m;
    bit  prev_left_acc, prev_stall;
    logic [OW-1:0] prev_opc;
    logic [AW-1:0] prev_addr;
    bit  prev_half;
    bit  after_reset;

    function automatic logic [19:0] slot_of(int w, bit h);
        return h ? mem[w][19:0] : mem[w][39:20];
    endfunction

    task automatic model_reset();
        pc_m = 0; half_m = 0; d_pend = 0; d_read_seen = 0;
        prev_left_acc = 0; prev_stall = 0; after_reset = 1;
    endtask

    task automatic do_reset(input int cyc);
        @(negedge clk);
        rst = 1; iss_ready = 0; data_req = 0; redir_valid = 0;
        repeat (cyc) @(negedge clk);
        rst = 0;
        model_reset();
        #1;
        check(!iss_valid && !mem_rd && !data_valid, "R1", "outputs quiet after reset",
              {iss_valid, mem_rd, data_valid}, 0);
    endtask

    task automatic step(input bit rdy, input bit dreq, input bit rv,
                        input logic [AW-1:0] rw, input bit rh);
        bit acc;
        logic [19:0] exp_slot;
        @(negedge clk);
        iss_ready = rdy; data_req = dreq; redir_valid = rv;
        redir_word = rw; redir_half = rh;
        #1;
        // R4: right half follows the left with no read
        if (prev_left_acc) begin
            check(iss_valid && iss_half && !mem_rd, "R4", "second half from buffer",
                  {iss_valid, iss_half, mem_rd}, 3'b110);
        end
        // R6: stall holds the payload
        if (prev_stall) begin
            check(iss_valid && iss_opcode == prev_opc && iss_addr == prev_addr
                  && iss_half == prev_half, "R6", "held during stall",
                  {iss_valid, iss_opcode, iss_addr}, {1'b1, prev_opc, prev_addr});
        end
        // R2 / R9 / R1: every read address
        if (mem_rd) begin
            if (d_pend && !d_read_seen) begin
                check(mem_addr == daddr_m[AW-1:0], "R9", "operand read address", mem_addr, daddr_m);
                d_read_seen = 1;
            end else begin
                check(mem_addr == pc_m[AW-1:0],
                      after_reset ? "R1" : "R2", "instruction read address", mem_addr, pc_m);
                after_reset = 0;
            end
        end
        if (data_valid) begin
            check(d_pend && d_read_seen && data_word == mem[daddr_m], "R9", "operand word",
                  data_word, mem[daddr_m]);
            d_pend = 0; d_read_seen = 0; data_results++;
        end
        acc = iss_valid && iss_ready;
        if (acc) begin
            exp_slot = slot_of(pc_m, half_m);
            check(iss_opcode == exp_slot[19:12] && iss_addr == exp_slot[11:0] && iss_half == half_m,
                  half_m ? "R5" : "R3", "issued instruction",
                  {iss_half, iss_opcode, iss_addr}, {half_m, exp_slot});
            accepts++;
            if (half_m) half2_issues++;
        end
        prev_left_acc = acc && !iss_half && !rv;
        prev_stall    = iss_valid && !iss_ready && !rv && !dreq;
        prev_opc = iss_opcode; prev_addr = iss_addr; prev_half = iss_half;
        if (iss_valid && !iss_ready && dreq && !rv) begin
            d_pend = 1; d_read_seen = 0; daddr_m = int'(iss_addr);
        end
        if (rv) begin
            pc_m = int'(rw); half_m = rh; d_pend = 0; d_read_seen = 0;
        end else if (acc) begin
            if (half_m) begin pc_m = (pc_m + 1) % DEPTH; half_m = 0; end
            else half_m = 1;
        end
    endtask

    // R7 directed: redirect to second half, check next valid is right and read is target
    task automatic directed_redirect(input int w, input bit h);
        int guard;
        logic [19:0] s;
        step(0, 0, 1, w[AW-1:0], h);
        #0;
        @(negedge clk); #1;
        check(!iss_valid, "R7", "valid dropped after redirect", iss_valid, 0);
        guard = 0;
        while (!iss_valid && guard < 20) begin
            step(0, 0, 0, '0, 0);
            guard++;
        end
        s = slot_of(w, h);
        check(iss_valid && iss_half == h && iss_opcode == s[19:12] && iss_addr == s[11:0],
              "R7", "redirect target instruction", {iss_half, iss_opcode, iss_addr}, {h, s});
    endtask

    initial begin
        for (int a = 0; a < DEPTH; a++) mem[a] = {$urandom(), $urandom()};
        mem[DEPTH-1] = 40'h12_345_67_89A;
        do_reset(3);
        // R10: data_req with no instruction pending must not start an operand read
        for (int i = 0; i < 3; i++) step(1, 1, 0, '0, 0);
        for (int i = 0; i < 30; i++) step(1, 0, 0, '0, 0);
        directed_redirect(77, 1);
        for (int i = 0; i < 10; i++) step(1, 0, 0, '0, 0);
        directed_redirect(DEPTH-1, 0);   // R5: wrap to word 0 after this pair
        for (int i = 0; i < 20; i++) step(1, 0, 0, '0, 0);
        // R8: redirect together with a handshake
        step(1, 1, 1, 12'd300, 0);
        for (int i = 0; i < 10; i++) step(1, 0, 0, '0, 0);
        for (int c = 0; c < RUN_CYCLES; c++) begin
            bit rdy, dq, rv;
            rdy = ($urandom_range(0, 9) < 6);
            dq  = ($urandom_range(0, 9) < 2);
            rv  = ($urandom_range(0, 99) < 3);
            step(rdy, dq, rv, 12'($urandom()), 1'($urandom()));
            if (c == RUN_CYCLES / 2) do_reset(2);
        end
        check(accepts > 1000, "R3", "forward progress", accepts, 1000);
        check(half2_issues > 500, "R4", "second halves issued", half2_issues, 500);
        check(data_results > 50, "R9", "operand reads completed", data_results, 50);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(10 * 150000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL R1 watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule